// File: doc/BRIEF.md
# Multiprocessor-Filtered UART Receiver

This block receives asynchronous serial characters from a line that is sampled at sixteen times the bit rate. A character is a low start bit, eight data bits with the least significant bit first, an optional flag bit and a high stop bit. The flag bit marks a character as an address (1) or as data (0), and it is present only while multiprocessor mode is selected. Each accepted character is placed in a held data register, and status flags report a full register, a bad stop bit and a lost character. Software lowers these flags through one-cycle clear strobes.

Several receivers can share one line, each listening only for addresses. Software sets the wake-up enable, and the receiver then discards every data character without touching its register or flags and without raising interrupts. The first character whose flag bit is 1 clears the wake-up enable in hardware, is received normally and sets the received-flag status bit. The wake-up enable has an effect only in asynchronous multiprocessor operation. The data register is read at any time while the full flag is set, so the output is a held register with plain flags and has no stream handshake.

Top module: `mprx_top`

## Requirements
- R1: After reset, rx_data is 0. rx_full, frame_err, overrun_err, mpb_rx, wake_en, rx_irq and err_irq are all 0.
- R2: A frame is sampled on os_tick pulses at 16 ticks per bit, using a majority of three samples at the bit centre. The frame is one 0 start bit, 8 data bits LSB first, then the flag bit only when mp_mode is 1, then one stop bit. An accepted character loads rx_data and sets rx_full.
- R3: An accepted character whose stop bit is sampled as 0 sets frame_err, and its data is still loaded.
- R4: An accepted character that completes while rx_full is 1 (and clr_full is not high in that cycle) sets overrun_err and leaves rx_data unchanged.
- R5: rx_full, frame_err and overrun_err fall only on their clear strobe. A clear that coincides with a character completion takes effect first, so the character then finds the register empty.
- R6: While wake_en is 1, mp_mode is 1 and sync_mode is 0, a character with flag bit 0 changes none of rx_data, rx_full, frame_err, overrun_err or mpb_rx, even when its stop bit is 0.
- R7: Under the conditions of R6, a character with flag bit 1 clears wake_en and sets mpb_rx. It is then received as in R2 to R4. This hardware clear has priority over a write on wake_wr.
- R8: With sync_mode 1 or mp_mode 0, wake_en keeps its written value and has no effect on reception or interrupts.
- R9: rx_irq is rx_full and err_irq is (frame_err or overrun_err), each gated by rx_ie and forced to 0 while the wake-up condition of R6 holds.
- R10: In mp_mode, every accepted character copies its flag bit to mpb_rx. With mp_mode 0, mpb_rx keeps its value.
- R11: If the start bit is sampled as 1 at its centre, the receiver returns to idle and delivers no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| sync_mode | input | 1 | 1 selects synchronous operation, which disables the wake-up filter |
| mp_mode | input | 1 | 1 adds the flag bit to each frame |
| wake_wr | input | 1 | Write strobe for the wake-up enable |
| wake_wdata | input | 1 | Value written to the wake-up enable |
| rx_ie | input | 1 | Receive interrupt enable |
| clr_full | input | 1 | Clear strobe for rx_full |
| clr_ferr | input | 1 | Clear strobe for frame_err |
| clr_oerr | input | 1 | Clear strobe for overrun_err |
| rx_data | output | 8 | Received data register |
| rx_full | output | 1 | Data register holds an unread character |
| frame_err | output | 1 | Stop bit was sampled as 0 |
| overrun_err | output | 1 | A character was lost because rx_full was set |
| mpb_rx | output | 1 | Flag bit of the last accepted character |
| wake_en | output | 1 | Wake-up enable state |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
A character can complete in the same cycle in which software strobes clr_full, and the result decides between a normal load and an overrun. The bench first sends a frame at a fixed phase of the tick train and measures the number of cycles from the start bit to the rise of rx_full. It then replays a second frame at the same phase while the register is still full, pulsing clr_full only in the cycle before the measured rise. The run is judged correct when the new byte is in rx_data, rx_full stays set and overrun_err stays 0.

// File: rtl/mprx_pkg.sv
package mprx_pkg;
  typedef enum logic [0:0] {
    RX_IDLE = 1'b0,
    RX_RUN  = 1'b1
  } rx_state_e;

  localparam int VOTE_TAPS = 3;
endpackage

// File: rtl/mprx_sync.sv
module mprx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= 1'b1;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mprx_sampler.sv
module mprx_sampler
  import mprx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_s,
  input  logic              mp_mode,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              mp_bit,
  output logic              stop_ok
);
  localparam int PH_W     = $clog2(OS_RATE);
  localparam int MID      = OS_RATE / 2;
  localparam int BIT_W    = $clog2(DATA_W + 3);
  localparam int MP_IDX   = DATA_W + 1;
  localparam int STOP_MP  = DATA_W + 2;
  localparam int STOP_STD = DATA_W + 1;

  rx_state_e        state;
  logic [PH_W-1:0]  phase;
  logic [BIT_W-1:0] bit_idx;
  logic [1:0]       ones;
  logic [1:0]       ones_nx;
  logic             in_window;
  logic             decide;
  logic             bit_val;
  logic [BIT_W-1:0] stop_idx;

  always_comb begin
    in_window = (phase >= PH_W'(MID - 1)) && (phase <= PH_W'(MID + 1));
    ones_nx   = ones + 2'(in_window & rx_s);
    bit_val   = (ones_nx >= 2'(VOTE_TAPS / 2 + 1));
    decide    = (phase == PH_W'(MID + 1));
    stop_idx  = mp_mode ? BIT_W'(STOP_MP) : BIT_W'(STOP_STD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      phase   <= '0;
      bit_idx <= '0;
      ones    <= '0;
      done    <= 1'b0;
      data    <= '0;
      mp_bit  <= 1'b0;
      stop_ok <= 1'b0;
    end else begin
      done <= 1'b0;
      if (os_tick) begin
        case (state)
          RX_IDLE: begin
            if (!rx_s) begin
              state   <= RX_RUN;
              phase   <= PH_W'(1);
              bit_idx <= '0;
              ones    <= '0;
            end
          end
          RX_RUN: begin
            ones <= decide ? 2'd0 : ones_nx;
            if (phase == PH_W'(OS_RATE - 1)) begin
              phase   <= '0;
              bit_idx <= bit_idx + 1'b1;
            end else begin
              phase <= phase + 1'b1;
            end
            if (decide) begin
              if (bit_idx == '0) begin
                if (bit_val) state <= RX_IDLE;
              end else if (bit_idx == stop_idx) begin
                stop_ok <= bit_val;
                done    <= 1'b1;
                state   <= RX_IDLE;
                if (!mp_mode) mp_bit <= 1'b0;
              end else if (bit_idx == BIT_W'(MP_IDX)) begin
                mp_bit <= bit_val;
              end else begin
                data <= {bit_val, data[DATA_W-1:1]};
              end
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mprx_status.sv
module mprx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] ch_data,
  input  logic              ch_mp,
  input  logic              ch_stop_ok,
  input  logic              sync_mode,
  input  logic              mp_mode,
  input  logic              wake_wr,
  input  logic              wake_wdata,
  input  logic              rx_ie,
  input  logic              clr_full,
  input  logic              clr_ferr,
  input  logic              clr_oerr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              frame_err,
  output logic              overrun_err,
  output logic              mpb_rx,
  output logic              wake_en,
  output logic              rx_irq,
  output logic              err_irq
);
  logic wake_live;
  logic accept;
  logic wake_hit;
  logic full_kept;
  logic irq_gate;

  always_comb begin
    wake_live = wake_en & mp_mode & ~sync_mode;
    accept    = done & ~(wake_live & ~ch_mp);
    wake_hit  = done & wake_live & ch_mp;
    full_kept = rx_full & ~clr_full;
    irq_gate  = rx_ie & ~wake_live;
    rx_irq    = irq_gate & rx_full;
    err_irq   = irq_gate & (frame_err | overrun_err);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_full     <= 1'b0;
      frame_err   <= 1'b0;
      overrun_err <= 1'b0;
      mpb_rx      <= 1'b0;
      wake_en     <= 1'b0;
    end else begin
      rx_full     <= accept | full_kept;
      frame_err   <= (accept & ~ch_stop_ok) | (frame_err & ~clr_ferr);
      overrun_err <= (accept & full_kept) | (overrun_err & ~clr_oerr);
      if (accept && !full_kept) rx_data <= ch_data;
      if (accept && mp_mode)    mpb_rx  <= ch_mp;
      if (wake_hit)             wake_en <= 1'b0;
      else if (wake_wr)         wake_en <= wake_wdata;
    end
  end
endmodule

// File: rtl/mprx_top.sv
module mprx_top #(
  parameter int DATA_W      = 8,
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              sync_mode,
  input  logic              mp_mode,
  input  logic              wake_wr,
  input  logic              wake_wdata,
  input  logic              rx_ie,
  input  logic              clr_full,
  input  logic              clr_ferr,
  input  logic              clr_oerr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              frame_err,
  output logic              overrun_err,
  output logic              mpb_rx,
  output logic              wake_en,
  output logic              rx_irq,
  output logic              err_irq
);
  logic              rx_s;
  logic              ch_done;
  logic [DATA_W-1:0] ch_data;
  logic              ch_mp;
  logic              ch_stop_ok;

  mprx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s)
  );

  mprx_sampler #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_samp (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_s(rx_s),
    .mp_mode(mp_mode), .done(ch_done), .data(ch_data),
    .mp_bit(ch_mp), .stop_ok(ch_stop_ok)
  );

  mprx_status #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .done(ch_done), .ch_data(ch_data),
    .ch_mp(ch_mp), .ch_stop_ok(ch_stop_ok), .sync_mode(sync_mode),
    .mp_mode(mp_mode), .wake_wr(wake_wr), .wake_wdata(wake_wdata),
    .rx_ie(rx_ie), .clr_full(clr_full), .clr_ferr(clr_ferr),
    .clr_oerr(clr_oerr), .rx_data(rx_data), .rx_full(rx_full),
    .frame_err(frame_err), .overrun_err(overrun_err), .mpb_rx(mpb_rx),
    .wake_en(wake_en), .rx_irq(rx_irq), .err_irq(err_irq)
  );
endmodule

// File: rtl/mprx_chk.sv
module mprx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_mode,
  input logic              mp_mode,
  input logic              wake_wr,
  input logic              rx_ie,
  input logic              clr_full,
  input logic              clr_ferr,
  input logic              clr_oerr,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_full,
  input logic              frame_err,
  input logic              overrun_err,
  input logic              mpb_rx,
  input logic              wake_en,
  input logic              rx_irq,
  input logic              err_irq
);
  // R4
  overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_err) |-> $stable(rx_data));

  // R5
  full_falls_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full) |-> $past(clr_full));

  // R5
  ferr_falls_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_err) |-> $past(clr_ferr));

  // R5
  oerr_falls_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(overrun_err) |-> $past(clr_oerr));

  // R6
  asleep_freezes_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_en && mp_mode && !sync_mode && !clr_full && !clr_ferr && !clr_oerr)
    |=> (!wake_en || ($stable(rx_full) && $stable(frame_err) &&
         $stable(overrun_err) && $stable(rx_data) && $stable(mpb_rx))));

  // R7
  wake_char_marks_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wake_en) && !$past(wake_wr)) |-> (mpb_rx && rx_full));

  // R9
  rx_irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (rx_full && rx_ie));

  // R9
  err_irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> ((frame_err || overrun_err) && rx_ie));

  // R9
  asleep_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_en && mp_mode && !sync_mode) |-> (!rx_irq && !err_irq));
endmodule

bind mprx_top mprx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .mp_mode(mp_mode),
  .wake_wr(wake_wr), .rx_ie(rx_ie), .clr_full(clr_full),
  .clr_ferr(clr_ferr), .clr_oerr(clr_oerr), .rx_data(rx_data),
  .rx_full(rx_full), .frame_err(frame_err), .overrun_err(overrun_err),
  .mpb_rx(mpb_rx), .wake_en(wake_en), .rx_irq(rx_irq), .err_irq(err_irq)
);

// File: tb/sim_mprx_top.sv
`timescale 1ns/1ps
module sim_mprx_top;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;
  localparam int NVEC     = 10;

  // fields: [26] clear first, [25] sync_mode, [24] mp_mode, [23] wake write,
  // [22] stop bit, [21] flag bit, [20:13] data sent,
  // [12:5] expected rx_data, [4:0] expected {full, ferr, oerr, mpb, wake}
  localparam logic [26:0] VEC [NVEC] = '{
    {1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,8'hA5, 8'hA5,5'b10000}, // R2
    {1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h3C, 8'hA5,5'b10100}, // R4
    {1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h0F, 8'h0F,5'b11000}, // R3
    {1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,8'h77, 8'h0F,5'b00001}, // R6
    {1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,8'h12, 8'h0F,5'b00001}, // R6
    {1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,8'h81, 8'h81,5'b10010}, // R7
    {1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,8'h5A, 8'h5A,5'b10000}, // R10
    {1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,8'hC3, 8'hC3,5'b10001}, // R8
    {1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,8'h99, 8'h99,5'b10001}, // R8
    {1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,8'hE7, 8'h99,5'b10110}  // R7 R4
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0;
  logic rxd = 1'b1;
  logic sync_mode = 1'b0, mp_mode = 1'b0, wake_wr = 1'b0, wake_wdata = 1'b0;
  logic rx_ie = 1'b0, clr_full = 1'b0, clr_ferr = 1'b0, clr_oerr = 1'b0;
  logic [7:0] rx_data;
  logic rx_full, frame_err, overrun_err, mpb_rx, wake_en, rx_irq, err_irq;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, t_start = 0, t_rise = 0, lat = 0;
  logic full_prev = 1'b0;
  logic done_flag = 1'b0;

  mprx_top u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .sync_mode(sync_mode), .mp_mode(mp_mode), .wake_wr(wake_wr),
    .wake_wdata(wake_wdata), .rx_ie(rx_ie), .clr_full(clr_full),
    .clr_ferr(clr_ferr), .clr_oerr(clr_oerr), .rx_data(rx_data),
    .rx_full(rx_full), .frame_err(frame_err), .overrun_err(overrun_err),
    .mpb_rx(mpb_rx), .wake_en(wake_en), .rx_irq(rx_irq), .err_irq(err_irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    @(negedge clk);
    os_tick = ((cyc % TICK_DIV) == TICK_DIV - 1);
  end

  initial forever begin
    @(negedge clk);
    if (rx_full && !full_prev) t_rise = cyc;
    full_prev = rx_full;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags(input logic f, input logic e, input logic o);
    clr_full = f; clr_ferr = e; clr_oerr = o;
    @(negedge clk);
    clr_full = 1'b0; clr_ferr = 1'b0; clr_oerr = 1'b0;
  endtask

  task automatic write_wake(input logic v);
    wake_wr = 1'b1; wake_wdata = v;
    @(negedge clk);
    wake_wr = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic fb, input logic stp, input logic with_fb);
    do @(negedge clk); while ((cyc % TICK_DIV) != 0);
    t_start = cyc;
    rxd = 1'b0; idle(BIT_CLKS);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; idle(BIT_CLKS); end
    if (with_fb) begin rxd = fb; idle(BIT_CLKS); end
    rxd = stp; idle(BIT_CLKS);
    rxd = 1'b1; idle(2 * BIT_CLKS);
  endtask

  function automatic logic [12:0] snap();
    return {rx_data, rx_full, frame_err, overrun_err, mpb_rx, wake_en};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    rx_ie = 1'b1;
    idle(3);
    // R1: reset state
    chk("R1 reset state", {19'd0, snap(), rx_irq, err_irq}, 32'd0);

    // R2 R3 R4 R6 R7 R8 R10: vector table
    for (int v = 0; v < NVEC; v++) begin
      sync_mode = VEC[v][25];
      mp_mode   = VEC[v][24];
      write_wake(VEC[v][23]);
      if (VEC[v][26]) clear_flags(1'b1, 1'b1, 1'b1);
      send_frame(VEC[v][20:13], VEC[v][21], VEC[v][22], VEC[v][24]);
      chk($sformatf("R2/R3/R4/R6/R7/R8/R10 vector %0d", v), {19'd0, snap()}, {19'd0, VEC[v][12:0]});
    end

    // R9: full and overrun pending, interrupts follow enable
    chk("R9 irq enabled", {30'd0, rx_irq, err_irq}, 32'd3);
    rx_ie = 1'b0; idle(1);
    chk("R9 irq disabled", {30'd0, rx_irq, err_irq}, 32'd0);

    // R5: only the strobed flag falls
    clear_flags(1'b0, 1'b0, 1'b1); idle(BIT_CLKS);
    chk("R5 single clear", {30'd0, rx_full, overrun_err}, 32'd2);

    // R9 R8: wake-up holds interrupts off only in async multiprocessor mode
    rx_ie = 1'b1; mp_mode = 1'b1; sync_mode = 1'b0;
    write_wake(1'b1); idle(1);
    chk("R9 wake holds irq", {31'd0, rx_irq}, 32'd0);
    sync_mode = 1'b1; idle(1);
    chk("R8 sync ignores wake", {31'd0, rx_irq}, 32'd1);
    sync_mode = 1'b0; write_wake(1'b0);

    // R5: completion and clear in the same cycle
    clear_flags(1'b1, 1'b1, 1'b1);
    send_frame(8'h11, 1'b0, 1'b1, 1'b1);
    lat = t_rise - t_start;
    chk("R5 measure frame", {24'd0, rx_data}, 32'h11);
    fork
      send_frame(8'h22, 1'b0, 1'b1, 1'b1);
      begin
        idle(4);
        while (cyc != t_start + lat - 1) @(negedge clk);
        clr_full = 1'b1;
        @(negedge clk);
        clr_full = 1'b0;
      end
    join
    chk("R5 clear meets completion", {21'd0, rx_data, rx_full, overrun_err, frame_err}, {21'd0, 8'h22, 3'b100});

    // R11: short low glitch is not a start bit
    clear_flags(1'b1, 1'b1, 1'b1);
    do @(negedge clk); while ((cyc % TICK_DIV) != 0);
    rxd = 1'b0; idle(3 * TICK_DIV);
    rxd = 1'b1; idle(3 * BIT_CLKS);
    chk("R11 false start", {31'd0, rx_full}, 32'd0);
    send_frame(8'h6B, 1'b0, 1'b1, 1'b1);
    chk("R11 frame after glitch", {23'd0, rx_data, rx_full}, {23'd0, 8'h6B, 1'b1});

    finish_run();
  end
endmodule